// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is a test-access data register that lets an external debug host reach a small file of on-chip debug registers through the boundary of a TAP controller. The host selects the chain, then walks the TAP through capture, shift and update. Each pass moves one 38-bit frame that holds a 32-bit data word, a 5-bit register index and a direction bit. On update, the frame either stores the data word into the indexed register or names that register as the one to return.

Reads are split-phase. A read frame only names a register. That register's contents appear in the data field when the next frame is captured, so a run of N reads costs N+1 scans. Every register keeps only the bits it implements, and unused high bits read as zero. Bit 4 of the debug control register is brought out as the monitor-mode enable. When the chain is not selected, TDI passes to TDO through one flop and the register file is left alone.

Top module: `dbg_scan_chain`

## Requirements
- R1: A frame is 38 bits and is shifted least significant bit first. Frame bits 0..31 are the data word, bits 32..36 the register index and bit 37 the direction flag. TDO presents frame bit 0 after capture and the next bit after each shift.
- R2: An update with direction flag 1 stores the data word into the indexed register, keeping only that register's implemented low bits.
- R3: An update with direction flag 0 nominates the indexed register. The next capture loads that register into frame bits 0..31 and loads zero into bits 32..37.
- R4: Index map: 0 debug control (6 bits), 1 debug status (5), 2 vector catch (8), 4 comms control (6), 5 comms data (32). Watchpoint unit 0 uses indices 8..13 and unit 1 uses 16..21. Within a unit the order is address value, address mask, data value, data mask (32 bits each), control value (9) and control mask (8).
- R5: Bits above a register's implemented width always read as zero.
- R6: Indices outside the map ignore writes and always read as zero.
- R7: Output mon_en equals bit 4 of debug control. That bit is writable and reads back as written.
- R8: Both tap_reset (synchronous, active high) and rst_n (asynchronous, active low) clear every register and return the nomination to index 0.
- R9: While chain_sel is 0, capture loads 0 into a single bypass flop and each shift moves TDI into it. TDO then shows TDI from one shift earlier, and no register changes.
- R10: A write frame leaves the current nomination unchanged, so the following capture still returns the register named by the last read frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| tap_reset | input | 1 | TAP in test-logic-reset, synchronous, active high |
| chain_sel | input | 1 | This chain is the selected data register |
| capture_dr | input | 1 | Capture strobe from the TAP |
| shift_dr | input | 1 | Shift strobe from the TAP |
| update_dr | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| mon_en | output | 1 | Monitor-mode enable, debug control bit 4 |

## Verification
A corrupted register or a wrong nomination is only visible at TDO, and only one whole scan later. It shows up in the data field captured at the start of the frame after the faulty update. The scoreboard therefore compares every captured frame, including the index and flag bits, which must be zero. A bad width mask shows as set bits above a register's width, and a decode slip shows as data appearing at an unmapped or neighbouring index. The monitor-mode enable is checked at the pin in the cycle after the update that writes it.

// File: rtl/dbgc_pkg.sv
`timescale 1ns/1ps
package dbgc_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 5;
  localparam int CHAIN_W  = DATA_W + ADDR_W + 1;
  localparam int NUM_ADDR = 1 << ADDR_W;

  // fixed index map
  localparam int IDX_DCTRL  = 0;
  localparam int IDX_DSTAT  = 1;
  localparam int IDX_VCATCH = 2;
  localparam int IDX_CCTRL  = 4;
  localparam int IDX_CDATA  = 5;
  localparam int WP_BASE    = 8;
  localparam int WP_STRIDE  = 8;
  localparam int NUM_WP     = 2;
  localparam int WP_REGS    = 6;
  localparam int WP_CVAL_OFS = 4;
  localparam int WP_CMSK_OFS = 5;

  // implemented widths
  localparam int DCTRL_W  = 6;
  localparam int DSTAT_W  = 5;
  localparam int VCATCH_W = 8;
  localparam int CCTRL_W  = 6;
  localparam int WP_CVAL_W = 9;
  localparam int WP_CMSK_W = 8;
  localparam int MON_BIT  = 4;

  // implemented width of an index, 0 when the index is unmapped
  function automatic int field_width(input logic [ADDR_W-1:0] a);
    int ai, off, unit, idx;
    ai = int'(32'(a));
    field_width = 0;
    case (ai)
      IDX_DCTRL:  field_width = DCTRL_W;
      IDX_DSTAT:  field_width = DSTAT_W;
      IDX_VCATCH: field_width = VCATCH_W;
      IDX_CCTRL:  field_width = CCTRL_W;
      IDX_CDATA:  field_width = DATA_W;
      default: begin
        if (ai >= WP_BASE) begin
          off  = ai - WP_BASE;
          unit = off / WP_STRIDE;
          idx  = off % WP_STRIDE;
          if (unit < NUM_WP && idx < WP_REGS) begin
            if (idx == WP_CVAL_OFS)      field_width = WP_CVAL_W;
            else if (idx == WP_CMSK_OFS) field_width = WP_CMSK_W;
            else                         field_width = DATA_W;
          end
        end
      end
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input logic [ADDR_W-1:0] a);
    int w;
    w = field_width(a);
    for (int i = 0; i < DATA_W; i++) width_mask[i] = (i < w);
  endfunction
endpackage

// File: rtl/dbgc_shift.sv
`timescale 1ns/1ps
module dbgc_shift #(
  parameter int DATA_W  = dbgc_pkg::DATA_W,
  parameter int CHAIN_W = dbgc_pkg::CHAIN_W
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tap_reset,
  input  logic               sel,
  input  logic               capture,
  input  logic               shift,
  input  logic               tdi,
  input  logic [DATA_W-1:0]  cap_data,
  output logic [CHAIN_W-1:0] frame,
  output logic               tdo
);
  logic [CHAIN_W-1:0] sr;
  logic               byp;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      byp <= 1'b0;
    end else if (tap_reset) begin
      sr  <= '0;
      byp <= 1'b0;
    end else if (sel) begin
      if (capture)    sr <= CHAIN_W'(cap_data);
      else if (shift) sr <= {tdi, sr[CHAIN_W-1:1]};
    end else begin
      if (capture)    byp <= 1'b0;
      else if (shift) byp <= tdi;
    end
  end

  assign frame = sr;
  assign tdo   = sel ? sr[0] : byp;

  AST_SHIFT_ORDER: assert property (@(posedge tck) disable iff (!rst_n || tap_reset)
    (sel && shift && !capture) |=> (sr[CHAIN_W-1] == $past(tdi) && sr[CHAIN_W-2:0] == $past(sr[CHAIN_W-1:1]))); // R1
  AST_CAPTURE_LOAD: assert property (@(posedge tck) disable iff (!rst_n || tap_reset)
    (sel && capture) |=> (sr[CHAIN_W-1:DATA_W] == '0 && sr[DATA_W-1:0] == $past(cap_data))); // R3
  AST_BYPASS_DELAY: assert property (@(posedge tck) disable iff (!rst_n || tap_reset)
    (!sel && shift && !capture) |=> (sel || tdo == $past(tdi))); // R9
endmodule

// File: rtl/dbgc_decode.sv
`timescale 1ns/1ps
module dbgc_decode #(
  parameter int ADDR_W   = dbgc_pkg::ADDR_W,
  parameter int NUM_ADDR = dbgc_pkg::NUM_ADDR
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_ADDR-1:0] hit
);
  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_hit
    localparam bit MAPPED = dbgc_pkg::field_width(ADDR_W'(a)) > 0;
    assign hit[a] = MAPPED && (addr == ADDR_W'(a));
  end

  always_comb begin
    AST_ONE_TARGET: assert ($onehot0(hit)); // R4
  end
endmodule

// File: rtl/dbgc_regfile.sv
`timescale 1ns/1ps
module dbgc_regfile #(
  parameter int DATA_W   = dbgc_pkg::DATA_W,
  parameter int ADDR_W   = dbgc_pkg::ADDR_W,
  parameter int NUM_ADDR = dbgc_pkg::NUM_ADDR
) (
  input  logic                tck,
  input  logic                rst_n,
  input  logic                tap_reset,
  input  logic                wr_en,
  input  logic [NUM_ADDR-1:0] wr_hit,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                nom_en,
  input  logic [ADDR_W-1:0]   nom_addr,
  output logic [ADDR_W-1:0]   nom_q,
  output logic [DATA_W-1:0]   rd_data,
  output logic                mon_en
);
  logic [NUM_ADDR-1:0][DATA_W-1:0] regs;

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_reg
    localparam int W = dbgc_pkg::field_width(ADDR_W'(a));
    if (W > 0) begin : g_impl
      logic [W-1:0] q;
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                  q <= '0;
        else if (tap_reset)          q <= '0;
        else if (wr_en && wr_hit[a]) q <= wdata[W-1:0];
      end
      assign regs[a] = DATA_W'(q);
    end else begin : g_hole
      assign regs[a] = '0;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)         nom_q <= '0;
    else if (tap_reset) nom_q <= '0;
    else if (nom_en)    nom_q <= nom_addr;
  end

  assign rd_data = regs[nom_q];
  assign mon_en  = regs[dbgc_pkg::IDX_DCTRL][dbgc_pkg::MON_BIT];

  AST_FULL_WORD_STORE: assert property (@(posedge tck) disable iff (!rst_n || tap_reset)
    (wr_en && wr_hit[dbgc_pkg::IDX_CDATA]) |=> (regs[dbgc_pkg::IDX_CDATA] == $past(wdata))); // R2
  AST_WRITE_KEEPS_NOM: assert property (@(posedge tck) disable iff (!rst_n || tap_reset)
    (wr_en && !nom_en) |=> $stable(nom_q)); // R10
endmodule

// File: rtl/dbg_scan_chain.sv
`timescale 1ns/1ps
module dbg_scan_chain (
  input  logic tck,
  input  logic rst_n,
  input  logic tap_reset,
  input  logic chain_sel,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic tdi,
  output logic tdo,
  output logic mon_en
);
  import dbgc_pkg::*;

  logic [CHAIN_W-1:0]  frame;
  logic [DATA_W-1:0]   upd_data;
  logic [ADDR_W-1:0]   upd_addr;
  logic                upd_write;
  logic                upd_fire;
  logic [NUM_ADDR-1:0] hit;
  logic [ADDR_W-1:0]   nom_q;
  logic [DATA_W-1:0]   rd_data;

  assign upd_data  = frame[DATA_W-1:0];
  assign upd_addr  = frame[DATA_W+ADDR_W-1:DATA_W];
  assign upd_write = frame[CHAIN_W-1];
  assign upd_fire  = update_dr && chain_sel;

  dbgc_shift u_shift (
    .tck(tck), .rst_n(rst_n), .tap_reset(tap_reset),
    .sel(chain_sel), .capture(capture_dr), .shift(shift_dr),
    .tdi(tdi), .cap_data(rd_data), .frame(frame), .tdo(tdo)
  );

  dbgc_decode u_decode (
    .addr(upd_addr), .hit(hit)
  );

  dbgc_regfile u_regs (
    .tck(tck), .rst_n(rst_n), .tap_reset(tap_reset),
    .wr_en(upd_fire && upd_write), .wr_hit(hit), .wdata(upd_data),
    .nom_en(upd_fire && !upd_write), .nom_addr(upd_addr),
    .nom_q(nom_q), .rd_data(rd_data), .mon_en(mon_en)
  );

  AST_MON_WRITE: assert property (@(posedge tck) disable iff (!rst_n || tap_reset)
    (upd_fire && upd_write && upd_addr == ADDR_W'(IDX_DCTRL)) |=> (mon_en == $past(upd_data[MON_BIT]))); // R7
  AST_MON_HOLD: assert property (@(posedge tck) disable iff (!rst_n || tap_reset)
    !(upd_fire && upd_write) |=> $stable(mon_en)); // R9
  AST_UPPER_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
    ((rd_data & ~width_mask(nom_q)) == '0)); // R5
  AST_HOLE_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
    (field_width(nom_q) == 0) |-> (rd_data == '0)); // R6
  AST_TAP_CLEAR: assert property (@(posedge tck) disable iff (!rst_n)
    tap_reset |=> (rd_data == '0 && !mon_en && nom_q == '0)); // R8
endmodule

// File: tb/dbg_scan_chain_test.sv
`timescale 1ns/1ps
module dbg_scan_chain_test;
  logic tck = 1'b0, rst_n = 1'b0, tap_reset = 1'b0, chain_sel = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  wire  tdo, mon_en;

  always #2.5 tck = ~tck;

  dbg_scan_chain uut (
    .tck(tck), .rst_n(rst_n), .tap_reset(tap_reset), .chain_sel(chain_sel),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .mon_en(mon_en)
  );

  int checks = 0, errors = 0;
  logic [31:0] mdl [32];
  int          mnom = 0;
  logic [37:0] exp_q [$];
  string       tag_q [$];
  logic [37:0] got_v;
  event        got_ev;

  // widths restated as a plain table
  function automatic int bw(input int a);
    case (a)
      0: return 6;  1: return 5;  2: return 8;  4: return 6;  5: return 32;
      8, 9, 10, 11, 16, 17, 18, 19: return 32;
      12, 20: return 9;
      13, 21: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] bmask(input int a);
    logic [63:0] one = 64'd1;
    return 32'((one << bw(a)) - 64'd1);
  endfunction

  function automatic string rtag(input int a);
    if (bw(a) == 0) return "R6";
    if (bw(a) < 32) return "R5";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    mnom = 0;
  endtask

  // driver: one full capture/shift/update pass, expected capture queued
  task automatic scan(input logic [31:0] d, input int a, input bit w, input string tag);
    logic [37:0] fr;
    fr = {w, 5'(a), d};
    exp_q.push_back({6'b0, mdl[mnom]});
    tag_q.push_back(tag == "" ? rtag(mnom) : tag);
    @(negedge tck); chain_sel = 1'b1; capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < 38; i++) begin
      tdi = fr[i];
      got_v[i] = tdo;
      @(negedge tck);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge tck); update_dr = 1'b0;
    -> got_ev;
    if (w) begin
      if (bw(a) > 0) mdl[a] = d & bmask(a);
    end else begin
      mnom = a;
    end
  endtask

  // monitor: compare each captured frame against the scoreboard
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) chk(1'b0, "R1", 64'(got_v), 64'd0);
      else begin
        logic [37:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(got_v == e, t, 64'(got_v), 64'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge tck);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    #12 rst_n = 1'b1;
    @(negedge tck);
    chk(mon_en == 1'b0, "R8", 64'(mon_en), 64'd0);

    // R1 R2: full-width write, then nominate and fetch
    scan(32'hA5A5_1234, 5, 1'b1, "R8");
    scan(32'h0, 5, 1'b0, "R1");
    scan(32'h0, 0, 1'b0, "R2");

    // R7: monitor enable via debug control bit 4
    scan(32'hFFFF_FFFF, 0, 1'b1, "R10");
    chk(mon_en == 1'b1, "R7", 64'(mon_en), 64'd1);
    scan(32'h0, 1, 1'b0, "R10"); // R10: the write left nomination at 0

    // R4 R5 R6: write every index then read every index
    for (int a = 0; a < 32; a++) scan(32'hFFFF_FFFF ^ (32'(a) * 32'h0101_0101), a, 1'b1, "");
    for (int a = 0; a < 32; a++) scan(32'h0, a, 1'b0, "R4");
    scan(32'h0, 0, 1'b0, "");

    // R9: bypass path when not selected
    @(negedge tck); chain_sel = 1'b0; capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
    chk(tdo == 1'b0, "R9", 64'(tdo), 64'd0);
    shift_dr = 1'b1;
    begin
      logic [7:0] p;
      p = 8'b1011_0010;
      for (int i = 0; i < 8; i++) begin
        tdi = p[i];
        @(negedge tck);
        chk(tdo == p[i], "R9", 64'(tdo), 64'(p[i]));
      end
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    @(negedge tck); update_dr = 1'b0;
    scan(32'h0, 13, 1'b0, "R9");
    scan(32'h0, 12, 1'b0, "R9");

    // R7: clear monitor enable
    scan(32'h0000_0020, 0, 1'b1, "");
    chk(mon_en == 1'b0, "R7", 64'(mon_en), 64'd0);
    scan(32'h0000_0010, 0, 1'b1, "");
    chk(mon_en == 1'b1, "R7", 64'(mon_en), 64'd1);

    // R8: TAP reset clears registers and nomination
    scan(32'h1F, 1, 1'b1, "");
    @(negedge tck); tap_reset = 1'b1;
    @(negedge tck); tap_reset = 1'b0;
    model_clear();
    chk(mon_en == 1'b0, "R8", 64'(mon_en), 64'd0);
    scan(32'h0, 1, 1'b0, "R8");
    scan(32'h0, 5, 1'b0, "R8");

    // R8: system reset
    scan(32'hDEAD_BEEF, 5, 1'b1, "");
    scan(32'h1F, 0, 1'b1, "");
    @(negedge tck); rst_n = 1'b0;
    @(negedge tck); rst_n = 1'b1;
    model_clear();
    chk(mon_en == 1'b0, "R8", 64'(mon_en), 64'd0);
    scan(32'h0, 5, 1'b0, "R8");
    scan(32'h0, 0, 1'b0, "R8");

    repeat (4) @(negedge tck);
    chk(exp_q.size() == 0, "R3", 64'(exp_q.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule